// File: doc/BRIEF.md
# Low-Power Mode Sequencer and Clock Gate

This block keeps track of which power mode a small microcontroller is in and turns that mode into clock enables for the peripherals. It follows five modes: full-speed run, wait, low-power run, low-power wait and a shallow stop. Decoded single-cycle pulses from the wait and stop instructions, an interrupt request line, a regulator-select bit and a wake-on-interrupt bit drive the transitions. The asynchronous active-low reset always returns the block to full-speed run.

Peripheral clocks are split into two banks. Each bank has a software mask register that is written through a simple write-enable port. In every mode except stop, each peripheral enable follows its mask bit. In stop, every peripheral enable is forced low. The only exception is the real-time-clock enable, which follows its mask bit in every mode. A separate debug-clock enable is high in run and wait and low in the two low-power modes. In stop it follows the debug-enable input.

Top module: `lpm_seq`

## Requirements
- R1: While rst_n is low, and after it is released, mode_oh reads RUN and both mask registers hold all ones, so every clock enable and dbg_clk_en read 1. The mode_oh encoding is: bit 0 RUN, bit 1 WAIT, bit 2 LPRUN, bit 3 LPWAIT, bit 4 STOP3.
- R2: In RUN, a wait_req pulse with lpr=0 moves the block to WAIT at the next edge. In WAIT, irq moves it to RUN at the next edge. Without irq it stays in WAIT.
- R3: In RUN or LPRUN, a stop_req pulse moves the block to STOP3 at the next edge. stop_req takes priority over wait_req.
- R4: In STOP3, irq wakes the block to RUN when lpr=0, or when lpr=1 and lpwui=1. When lpr=1 and lpwui=0, irq leaves the block in STOP3.
- R5: In RUN with lpr=1 and no pulse, the block enters LPRUN. In LPRUN, lpr=0 returns it to RUN and a wait_req pulse moves it to LPWAIT.
- R6: In LPWAIT, irq returns the block to RUN only when lpwui=1. Otherwise it stays in LPWAIT.
- R7: In RUN, a wait_req pulse while lpr=1 is a request to go straight to LPWAIT. It is ignored, and the block stays in RUN for that edge.
- R8: In STOP3, every bit of clk_en_a and clk_en_b is 0 regardless of the masks, except the real-time-clock bit.
- R9: dbg_clk_en is 1 in RUN and WAIT, 0 in LPRUN and LPWAIT, and equal to dbg_en in STOP3.
- R10: In RUN, WAIT, LPRUN and LPWAIT, each bit of clk_en_a and clk_en_b equals the same bit of its mask register.
- R11: The real-time-clock enable (bank A, bit RTC_BIT, default 1) equals its mask bit in every mode. The watchdog enable (bank A, bit WDOG_BIT, default 0) is 0 in STOP3.
- R12: When mask_a_we or mask_b_we is high at an edge, the matching mask register takes the write data at that edge.
- R13: An irq that cannot wake the current mode, or that arrives in RUN or LPRUN, changes nothing and is not remembered. A later change to lpwui without a new irq does not cause a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Decoded stop-instruction pulse |
| wait_req | input | 1 | Decoded wait-instruction pulse |
| irq | input | 1 | Interrupt request |
| lpr | input | 1 | Low-power regulator select |
| lpwui | input | 1 | Wake-on-interrupt from low-power modes |
| dbg_en | input | 1 | Keep debug clock alive in stop |
| mask_a_we | input | 1 | Write strobe for mask bank A |
| mask_a_wdata | input | NA | Write data for mask bank A |
| mask_b_we | input | 1 | Write strobe for mask bank B |
| mask_b_wdata | input | NB | Write data for mask bank B |
| mode_oh | output | 5 | One-hot current mode |
| clk_en_a | output | NA | Peripheral clock enables, bank A |
| clk_en_b | output | NB | Peripheral clock enables, bank B |
| dbg_clk_en | output | 1 | Debug-logic clock enable |

## Verification
The hardest cases to reach are an interrupt that arrives in stop, or in low-power wait, while the regulator bit is set and the wake bit is clear. The block must stay put, and it must not wake later when the wake bit is raised with no new interrupt. The stimulus walks one long mode trajectory from reset. It drives the blocked interrupt, then raises the wake bit with no interrupt, and only then sends a fresh interrupt. The ignored run-to-low-power-wait request is reached by pulsing wait_req in the same cycle that the regulator bit is first raised in run.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   // Mode states of the power sequencer.
   typedef enum logic [2:0] {
      MODE_RUN    = 3'd0,
      MODE_WAIT   = 3'd1,
      MODE_LPRUN  = 3'd2,
      MODE_LPWAIT = 3'd3,
      MODE_STOP3  = 3'd4
   } lpm_mode_e;

   localparam int unsigned NUM_MODES = 5;

   // Bit position of each mode in the one-hot mode vector.
   localparam int unsigned OH_RUN    = 0;
   localparam int unsigned OH_WAIT   = 1;
   localparam int unsigned OH_LPRUN  = 2;
   localparam int unsigned OH_LPWAIT = 3;
   localparam int unsigned OH_STOP3  = 4;

   function automatic logic [NUM_MODES-1:0] mode_to_oh(input lpm_mode_e m);
      logic [NUM_MODES-1:0] v;
      v = '0;
      unique case (m)
         MODE_RUN:    v[OH_RUN]    = 1'b1;
         MODE_WAIT:   v[OH_WAIT]   = 1'b1;
         MODE_LPRUN:  v[OH_LPRUN]  = 1'b1;
         MODE_LPWAIT: v[OH_LPWAIT] = 1'b1;
         MODE_STOP3:  v[OH_STOP3]  = 1'b1;
         default:     v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/lpm_fsm.sv
module lpm_fsm
   import lpm_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stop_req,
   input  logic                 wait_req,
   input  logic                 irq,
   input  logic                 lpr,
   input  logic                 lpwui,
   output lpm_mode_e            mode,
   output logic [NUM_MODES-1:0] mode_oh
);

   lpm_mode_e mode_q, mode_d;
   logic      stop_wake;
   logic      lpwait_wake;

   // A stop wake needs irq, and either the normal regulator or the wake bit.
   assign stop_wake   = irq & (~lpr | lpwui);
   assign lpwait_wake = irq & lpwui;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_RUN: begin
            if (stop_req)
               mode_d = MODE_STOP3;
            else if (wait_req)
               mode_d = lpr ? MODE_RUN : MODE_WAIT;  // direct move to LPWAIT refused
            else if (lpr)
               mode_d = MODE_LPRUN;
         end
         MODE_WAIT: begin
            if (irq)
               mode_d = MODE_RUN;
         end
         MODE_LPRUN: begin
            if (stop_req)
               mode_d = MODE_STOP3;
            else if (wait_req)
               mode_d = MODE_LPWAIT;
            else if (!lpr)
               mode_d = MODE_RUN;
         end
         MODE_LPWAIT: begin
            if (lpwait_wake)
               mode_d = MODE_RUN;
         end
         MODE_STOP3: begin
            if (stop_wake)
               mode_d = MODE_RUN;
         end
         default: mode_d = MODE_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= MODE_RUN;
      else
         mode_q <= mode_d;
   end

   assign mode    = mode_q;
   assign mode_oh = mode_to_oh(mode_q);

   // R1
   mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode_oh) == 1);

   // R2
   run_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_RUN && wait_req && !stop_req && !lpr) |=> mode_q == MODE_WAIT);

   // R4
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_STOP3 && lpr && !lpwui) |=> mode_q == MODE_STOP3);

   // R6
   lpwait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_LPWAIT && !lpwui) |=> mode_q == MODE_LPWAIT);

   // R7
   no_direct_lpwait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_RUN) |=> mode_q != MODE_LPWAIT);

   // R13
   stop_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_STOP3 && !irq) |=> mode_q == MODE_STOP3);

endmodule

// File: rtl/lpm_mask_bank.sv
module lpm_mask_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask
);

   if (W < 1) begin : g_bad_width
      $error("lpm_mask_bank: W must be at least 1");
   end

   logic [W-1:0] mask_q;

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[i] <= 1'b1;
         else if (we)
            mask_q[i] <= wdata[i];
      end
   end

   assign mask = mask_q;

   // R12
   mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mask == $past(wdata));

   // R12
   mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mask));

endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate #(
   parameter int unsigned W        = 8,
   parameter bit          HAS_RTC  = 1'b0,
   parameter int unsigned RTC_BIT  = 0,
   parameter bit          HAS_WDOG = 1'b0,
   parameter int unsigned WDOG_BIT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stop_mode,
   input  logic [W-1:0] mask,
   output logic [W-1:0] clk_en
);

   if (HAS_RTC && RTC_BIT >= W) begin : g_bad_rtc
      $error("lpm_clk_gate: RTC_BIT out of range");
   end
   if (HAS_WDOG && WDOG_BIT >= W) begin : g_bad_wdog
      $error("lpm_clk_gate: WDOG_BIT out of range");
   end
   if (HAS_RTC && HAS_WDOG && RTC_BIT == WDOG_BIT) begin : g_bad_share
      $error("lpm_clk_gate: RTC_BIT and WDOG_BIT must differ");
   end

   for (genvar i = 0; i < W; i++) begin : g_en
      if (HAS_RTC && i == RTC_BIT) begin : g_rtc
         assign clk_en[i] = mask[i];
      end else begin : g_periph
         assign clk_en[i] = mask[i] & ~stop_mode;
      end
   end

   // R10
   run_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_mode |-> clk_en == mask);

   // R8
   stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_mode |-> $countones(clk_en) <= (HAS_RTC ? 1 : 0));

   if (HAS_RTC) begin : g_rtc_chk
      // R11
      rtc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clk_en[RTC_BIT] == mask[RTC_BIT]);
   end

   if (HAS_WDOG) begin : g_wdog_chk
      // R11
      wdog_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         stop_mode |-> !clk_en[WDOG_BIT]);
   end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
   import lpm_pkg::*;
#(
   parameter int unsigned NA        = 8,
   parameter int unsigned NB        = 8,
   parameter int unsigned RTC_BANK  = 0,
   parameter int unsigned RTC_BIT   = 1,
   parameter int unsigned WDOG_BANK = 0,
   parameter int unsigned WDOG_BIT  = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stop_req,
   input  logic          wait_req,
   input  logic          irq,
   input  logic          lpr,
   input  logic          lpwui,
   input  logic          dbg_en,
   input  logic          mask_a_we,
   input  logic [NA-1:0] mask_a_wdata,
   input  logic          mask_b_we,
   input  logic [NB-1:0] mask_b_wdata,
   output logic [4:0]    mode_oh,
   output logic [NA-1:0] clk_en_a,
   output logic [NB-1:0] clk_en_b,
   output logic          dbg_clk_en
);

   localparam bit RTC_IN_A  = (RTC_BANK == 0);
   localparam bit RTC_IN_B  = (RTC_BANK == 1);
   localparam bit WDOG_IN_A = (WDOG_BANK == 0);
   localparam bit WDOG_IN_B = (WDOG_BANK == 1);

   if (RTC_BANK > 1 || WDOG_BANK > 1) begin : g_bad_bank
      $error("lpm_seq: bank selects must be 0 or 1");
   end
   if (NUM_MODES != 5) begin : g_bad_modes
      $error("lpm_seq: mode vector width mismatch");
   end

   lpm_mode_e     mode;
   logic [NA-1:0] mask_a;
   logic [NB-1:0] mask_b;
   logic          stop_mode;
   logic          lp_mode;

   lpm_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop_req (stop_req),
      .wait_req (wait_req),
      .irq      (irq),
      .lpr      (lpr),
      .lpwui    (lpwui),
      .mode     (mode),
      .mode_oh  (mode_oh)
   );

   lpm_mask_bank #(.W(NA)) u_mask_a (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mask_a_we),
      .wdata (mask_a_wdata),
      .mask  (mask_a)
   );

   lpm_mask_bank #(.W(NB)) u_mask_b (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mask_b_we),
      .wdata (mask_b_wdata),
      .mask  (mask_b)
   );

   assign stop_mode = mode_oh[OH_STOP3];
   assign lp_mode   = mode_oh[OH_LPRUN] | mode_oh[OH_LPWAIT];

   lpm_clk_gate #(
      .W(NA), .HAS_RTC(RTC_IN_A), .RTC_BIT(RTC_BIT),
      .HAS_WDOG(WDOG_IN_A), .WDOG_BIT(WDOG_BIT)
   ) u_gate_a (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_mode (stop_mode),
      .mask      (mask_a),
      .clk_en    (clk_en_a)
   );

   lpm_clk_gate #(
      .W(NB), .HAS_RTC(RTC_IN_B), .RTC_BIT(RTC_BIT),
      .HAS_WDOG(WDOG_IN_B), .WDOG_BIT(WDOG_BIT)
   ) u_gate_b (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_mode (stop_mode),
      .mask      (mask_b),
      .clk_en    (clk_en_b)
   );

   // Debug clock: on at full power, off in low-power modes, kept by dbg_en in stop.
   always_comb begin
      if (stop_mode)
         dbg_clk_en = dbg_en;
      else
         dbg_clk_en = ~lp_mode;
   end

   // R9
   dbg_lp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_LPRUN || mode == MODE_LPWAIT) |-> !dbg_clk_en);

   // R9
   dbg_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_STOP3) |-> dbg_clk_en == dbg_en);

   // R3
   stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MODE_RUN || mode == MODE_LPRUN) && stop_req) |=> mode == MODE_STOP3);

endmodule

// File: tb/lpm_seq_test.sv
module lpm_seq_test;

   localparam int NA = 8;
   localparam int NB = 8;
   localparam int NV = 21;

   // Row: [13:10] requirement number, [9:5] {stop,wait,irq,lpr,lpwui}, [4:0] expected mode.
   // Mode one-hot: RUN 00001, WAIT 00010, LPRUN 00100, LPWAIT 01000, STOP3 10000.
   localparam logic [13:0] VEC [NV] = '{
      {4'd2,  5'b01000, 5'b00010},  // R2 run -> wait
      {4'd2,  5'b00000, 5'b00010},  // R2 wait holds
      {4'd2,  5'b00100, 5'b00001},  // R2 irq wakes wait
      {4'd13, 5'b00100, 5'b00001},  // R13 irq in run no effect
      {4'd3,  5'b10000, 5'b10000},  // R3 run -> stop
      {4'd4,  5'b00100, 5'b00001},  // R4 wake, lpr=0
      {4'd3,  5'b10000, 5'b10000},  // R3
      {4'd4,  5'b00110, 5'b10000},  // R4 blocked wake
      {4'd13, 5'b00011, 5'b10000},  // R13 not latched
      {4'd4,  5'b00111, 5'b00001},  // R4 wake with lpwui
      {4'd7,  5'b01010, 5'b00001},  // R7 refused direct lpwait
      {4'd5,  5'b00010, 5'b00100},  // R5 run -> lprun
      {4'd13, 5'b00110, 5'b00100},  // R13 irq in lprun
      {4'd5,  5'b01010, 5'b01000},  // R5 lprun -> lpwait
      {4'd6,  5'b00110, 5'b01000},  // R6 blocked
      {4'd6,  5'b00111, 5'b00001},  // R6 wake
      {4'd5,  5'b00010, 5'b00100},  // R5
      {4'd3,  5'b10010, 5'b10000},  // R3 lprun -> stop
      {4'd4,  5'b00100, 5'b00001},  // R4
      {4'd5,  5'b00010, 5'b00100},  // R5
      {4'd5,  5'b00000, 5'b00001}   // R5 lprun -> run
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stop_req = 1'b0, wait_req = 1'b0, irq = 1'b0;
   logic          lpr = 1'b0, lpwui = 1'b0, dbg_en = 1'b0;
   logic          mask_a_we = 1'b0, mask_b_we = 1'b0;
   logic [NA-1:0] mask_a_wdata = '0;
   logic [NB-1:0] mask_b_wdata = '0;
   logic [4:0]    mode_oh;
   logic [NA-1:0] clk_en_a;
   logic [NB-1:0] clk_en_b;
   logic          dbg_clk_en;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lpm_seq #(.NA(NA), .NB(NB)) uut (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
      .irq(irq), .lpr(lpr), .lpwui(lpwui), .dbg_en(dbg_en),
      .mask_a_we(mask_a_we), .mask_a_wdata(mask_a_wdata),
      .mask_b_we(mask_b_we), .mask_b_wdata(mask_b_wdata),
      .mode_oh(mode_oh), .clk_en_a(clk_en_a), .clk_en_b(clk_en_b),
      .dbg_clk_en(dbg_clk_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive inputs at the falling edge, then sample 1 ns after the rising edge.
   task automatic step(input logic [4:0] in);
      @(negedge clk);
      {stop_req, wait_req, irq, lpr, lpwui} = in;
      @(posedge clk);
      #1;
      {stop_req, wait_req, irq} = 3'b000;
   endtask

   task automatic write_masks(input logic [NA-1:0] a, input logic [NB-1:0] b);
      @(negedge clk);
      mask_a_we = 1'b1; mask_a_wdata = a;
      mask_b_we = 1'b1; mask_b_wdata = b;
      @(posedge clk);
      #1;
      mask_a_we = 1'b0; mask_b_we = 1'b0;
   endtask

   initial begin
      #3;
      // R1: values during reset
      check("R1", 32'(mode_oh), 32'h01);
      check("R1", 32'(clk_en_a), 32'hFF);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1", 32'(mode_oh), 32'h01);
      check("R1", 32'({clk_en_a, clk_en_b}), 32'hFFFF);
      check("R9", 32'(dbg_clk_en), 32'h1);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][9:5]);
         total++;
         if (mode_oh !== VEC[i][4:0]) begin
            bad++;
            $display("FAIL R%0d row %0d: actual=%b expected=%b", VEC[i][13:10], i, mode_oh, VEC[i][4:0]);
         end
      end

      // R12 / R10: mask write in RUN shows at the enables after the write edge
      write_masks(8'hA7, 8'h3C);
      check("R12", 32'(clk_en_a), 32'hA7);
      check("R10", 32'(clk_en_b), 32'h3C);

      // R10 / R9 in LPRUN
      step(5'b00010);
      check("R5", 32'(mode_oh), 32'h04);
      check("R10", 32'({clk_en_a, clk_en_b}), 32'hA73C);
      check("R9", 32'(dbg_clk_en), 32'h0);

      // R8 / R11 in STOP3: only the RTC bit (bit 1) survives, watchdog bit 0 is off
      dbg_en = 1'b0;
      step(5'b10010);
      check("R8", 32'(clk_en_b), 32'h00);
      check("R11", 32'(clk_en_a), 32'h02);
      check("R9", 32'(dbg_clk_en), 32'h0);
      @(negedge clk);
      dbg_en = 1'b1;
      #1;
      check("R9", 32'(dbg_clk_en), 32'h1);

      // R11: RTC enable follows a mask change while in stop
      write_masks(8'hA5, 8'hFF);
      check("R11", 32'(clk_en_a), 32'h00);
      check("R8", 32'(clk_en_b), 32'h00);

      // R1: reset in stop together with a stop pulse returns to RUN, masks back to ones
      @(negedge clk);
      stop_req = 1'b1;
      rst_n = 1'b0;
      #1;
      check("R1", 32'(mode_oh), 32'h01);
      check("R1", 32'(clk_en_a), 32'hFF);
      @(negedge clk);
      stop_req = 1'b0;
      lpr = 1'b0;
      lpwui = 1'b0;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1", 32'(mode_oh), 32'h01);

      // R3: stop wins over wait in the same cycle
      step(5'b11000);
      check("R3", 32'(mode_oh), 32'h10);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule